// File: doc/BRIEF.md
# Suspend Warning Acknowledge Delay

This block answers an active-low suspend-warning input with an active-low suspend-acknowledge output after a programmable wait. The wait is held in a 4-bit delay field, one unit per half-second tick. A free-running prescaler makes that tick from the system clock. The number of clocks per tick is a parameter, so a simulation can use a short tick. Because the tick keeps running on its own, a setting of N produces an acknowledge between N and N+1 tick periods after the warning arrives. The default setting of 7 therefore gives between 3.5 s and 4 s, and a setting of 0 gives an acknowledge before the current tick ends.

The warning input passes through a two-flop synchronizer before it is used. While the synchronized warning is active, the block counts ticks and compares the count with the delay field. If the warning goes away early, the count clears, so the next warning gets the full delay. The acknowledge is gated by the raw warning pin, so it goes inactive in the same clock cycle that the warning is removed. A write strobe loads the delay field. The read port returns the field in bits 3..0 and zeros in bits 7..4.

Top module: `swd_ack_delay`

## Requirements
- R1: After reset, ack_n is 1, and cfg_rdata reads 8'h07 (delay field = 7).
- R2: A clock edge with cfg_we = 1 loads cfg_wdata into the delay field. From the next cycle, cfg_rdata[3:0] shows the written value, and cfg_rdata[7:4] is always 0.
- R3: With delay setting N and warn_n driven low just before clock edge 1 (and high before that), ack_n first goes low right after a clock edge k, where N*TICK_CLKS + 3 <= k <= N*TICK_CLKS + TICK_CLKS + 2.
- R4: With delay setting 0, ack_n goes low within the first tick period, that is 3 <= k <= TICK_CLKS + 2.
- R5: If warn_n returns high before the acknowledge, ack_n stays 1 and the tick count clears. A later warning then waits the full window of R3 again.
- R6: ack_n goes high in the same cycle that warn_n goes high, with no clock edge in between.
- R7: While warn_n stays low, ack_n stays low once it has gone low.
- R8: The internal tick pulses exactly once every TICK_CLKS clocks. The acknowledge only ever asserts on the edge that follows a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the delay field |
| cfg_wdata | input | 4 | New delay setting, in ticks |
| cfg_rdata | output | 8 | Register read value: delay field in [3:0], zeros in [7:4] |
| warn_n | input | 1 | Suspend warning, active low, asynchronous |
| ack_n | output | 1 | Suspend acknowledge, active low |

## Verification
The bench measures the acknowledge latency for settings 0, 1, 5, 7 and 15 against a window exactly one tick wide. An off-by-one in the tick comparison, or a count that starts from one instead of zero, therefore lands outside the window. An early-removal scenario catches a counter that is not cleared: such a design acknowledges too soon on the next warning. The release check samples just after warn_n rises, with no clock edge in between. A design whose acknowledge waits for the synchronized warning would still show 0 there. A write of the maximum value and a check of the reserved bits catch truncation and leakage of the field.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int unsigned DLY_W = 4;
    localparam int unsigned REG_W = 8;

    typedef logic [DLY_W-1:0] dly_t;

    typedef struct packed {
        dly_t cnt;
        logic ack;
    } ctr_state_t;

endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic active
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], din_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pipe: '1};
        else        s_q <= s_d;
    end

    assign active = ~s_q.pipe[STAGES-1];
endmodule

// File: rtl/swd_prescale.sv
module swd_prescale #(
    parameter int unsigned TICK_CLKS = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (TICK_CLKS > 2) ? $clog2(TICK_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.cnt == LAST) p_d.cnt = '0;
        else                 p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{cnt: '0};
        else        p_q <= p_d;
    end

    assign tick = (p_q.cnt == LAST);
endmodule

// File: rtl/swd_cfg_reg.sv
module swd_cfg_reg
    import swd_pkg::*;
#(
    parameter int unsigned DLY_RST = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  dly_t             wdata,
    output dly_t             delay,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        dly_t field;
    } cfg_state_t;

    cfg_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) c_d.field = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{field: dly_t'(DLY_RST)};
        else        c_q <= c_d;
    end

    assign delay = c_q.field;
    assign rdata = {{(REG_W-DLY_W){1'b0}}, c_q.field};
endmodule

// File: rtl/swd_delay_ctr.sv
module swd_delay_ctr
    import swd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warn_act,
    input  logic tick,
    input  dly_t delay,
    output dly_t cnt,
    output logic ack
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!warn_act) begin
            st_d.cnt = '0;
            st_d.ack = 1'b0;
        end else if (!st_q.ack && tick) begin
            if (st_q.cnt == delay) st_d.ack = 1'b1;
            else                   st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, ack: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ack = st_q.ack;
endmodule

// File: rtl/swd_ack_delay.sv
module swd_ack_delay
    import swd_pkg::*;
#(
    parameter int unsigned TICK_CLKS = 50_000_000,
    parameter int unsigned DLY_RST   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DLY_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             warn_n,
    output logic             ack_n
);
    logic tick;
    logic warn_act;
    logic ack_q;
    dly_t delay;
    dly_t cnt;

    swd_prescale #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    swd_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_n(warn_n), .active(warn_act)
    );

    swd_cfg_reg #(.DLY_RST(DLY_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .delay(delay), .rdata(cfg_rdata)
    );

    swd_delay_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .warn_act(warn_act), .tick(tick),
        .delay(delay), .cnt(cnt), .ack(ack_q)
    );

    // Raw pin gates the output so release is seen without sync latency.
    assign ack_n = ~(ack_q & ~warn_n);
endmodule

// File: rtl/swd_ack_delay_chk.sv
module swd_ack_delay_chk
    import swd_pkg::*;
#(
    parameter int unsigned TICK_CLKS = 50_000_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [DLY_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             warn_n,
    input logic             ack_n,
    input logic             tick,
    input logic             warn_act,
    input dly_t             cnt,
    input logic             ack_q
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap_q <= 0;
        else if (tick) gap_q <= 0;
        else           gap_q <= gap_q + 1;
    end

    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == TICK_CLKS - 1));

    a_r8_ack_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_n) && $past(!warn_n)) |-> $past(tick));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[DLY_W-1:0] == $past(cfg_wdata)));

    a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !warn_act |=> (cnt == '0 && !ack_q));

    a_r7_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !warn_n) |=> (warn_n || !ack_n));

    a_r6_release_now: assert property (@(posedge clk) disable iff (!rst_n)
        warn_n |-> ack_n);
endmodule

bind swd_ack_delay swd_ack_delay_chk #(.TICK_CLKS(TICK_CLKS)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .warn_n(warn_n), .ack_n(ack_n), .tick(tick),
    .warn_act(warn_act), .cnt(cnt), .ack_q(ack_q)
);

// File: tb/swd_ack_delay_tb_top.sv
module swd_ack_delay_tb_top;
    localparam int unsigned T = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       warn_n = 1'b1;
    logic       ack_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    swd_ack_delay #(.TICK_CLKS(T), .DLY_RST(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .warn_n(warn_n), .ack_n(ack_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_dly(input int v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 4'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_rdata == 8'(v), "R2 readback", cfg_rdata, v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Asserts warning, returns edges until ack_n low (or limit+1).
    task automatic wait_ack(output int lat);
        int limit = 17 * T + 10;
        lat = 0;
        @(negedge clk);
        warn_n = 1'b0;
        while (lat <= limit) begin
            @(negedge clk);
            lat++;
            if (!ack_n) break;
        end
    endtask

    task automatic t_reset();
        chk(ack_n == 1'b1, "R1 ack idle", ack_n, 1);
        chk(cfg_rdata == 8'h07, "R1 default delay", cfg_rdata, 7);
    endtask

    task automatic t_latency(input int n, input bit do_write, input string req);
        int lat;
        int lo = n * T + 3;
        int hi = n * T + T + 2;
        if (do_write) write_dly(n);
        idle(4);
        wait_ack(lat);
        chk(lat >= lo && lat <= hi, req, lat, lo);
        idle(2 * T);
        chk(ack_n == 1'b0, "R7 ack held", ack_n, 0);
        warn_n = 1'b1;
        #1;
        chk(ack_n == 1'b1, "R6 same-cycle release", ack_n, 1);
        idle(5);
    endtask

    task automatic t_abort();
        int lat;
        bit seen = 1'b0;
        write_dly(3);
        idle(4);
        @(negedge clk);
        warn_n = 1'b0;
        for (int i = 0; i < 2 * T; i++) begin
            @(negedge clk);
            if (!ack_n) seen = 1'b1;
        end
        chk(!seen, "R5 no ack before expiry", seen, 0);
        warn_n = 1'b1;
        idle(6);
        wait_ack(lat);
        chk(lat >= 3 * T + 3 && lat <= 4 * T + 2, "R5 full delay after restart", lat, 3 * T + 3);
        warn_n = 1'b1;
        idle(5);
    endtask

    task automatic t_reserved();
        write_dly(15);
        chk(cfg_rdata[7:4] == 4'h0, "R2 reserved bits zero", cfg_rdata[7:4], 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency(7, 1'b0, "R3 default setting window");
        t_latency(0, 1'b1, "R4 zero setting window");
        t_latency(1, 1'b1, "R3 setting 1 window");
        t_latency(5, 1'b1, "R3 setting 5 window");
        t_reserved();
        t_latency(15, 1'b0, "R3 setting 15 window");
        t_abort();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100_000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule